// File: doc/BRIEF.md
# Colored VLIW Instruction Memory

This block stores the wide instructions that a match-action stage sends to its array of field ALUs. The memory has a fixed number of rows, and each row holds one instruction slot per ALU. Every slot also carries one color bit. Because of this bit, two actions whose written ALUs do not overlap can share one physical row. An action is named by a (row, color) pair. When an action runs, only the slots of its row that carry its color contribute to the output.

Each cycle the stage presents several requests. Each request has a valid bit, a row and a color. The block masks every selected row by its requested color and ORs all the masked rows into one VLIW word. It then registers that word for the ALUs. A slot value of zero is a noop, so an ALU whose slot stays zero lets its field through unchanged. Row 0 is the noop row and writes to it are dropped. A request whose bits are all zero therefore always produces a noop. If two requests put nonzero slots on the same ALU, the OR garbles that instruction. The block still outputs the OR and raises a conflict flag for that cycle.

A write port loads one slot per cycle: the instruction bits together with the slot's color bit.

Top module: `vliw_imem`

## Requirements
- R1: After reset, vliw_q and conflict_q are zero, and every slot and color bit in the memory is zero, so any request returns an all-zero word.
- R2: A single valid request (row, color) yields a vliw_q in which slot a occupies bits [a*SLOT_W +: SLOT_W]. Slot a equals the stored slot when that slot's color bit equals the requested color, and is zero otherwise.
- R3: A request whose valid bit is 0 contributes zero to vliw_q and cannot raise conflict_q.
- R4: vliw_q is the bitwise OR of the masked contributions of all valid requests in the same cycle.
- R5: Two actions stored in one row under colors 0 and 1 are returned separately by requests for each color. Requesting both colors of that row returns their union.
- R6: Writes to row 0 are ignored. Any valid request to row 0, including the all-zero request (row 0, color 0), contributes zero.
- R7: A write with wr_en=1 to row r (r not 0) and slot s sets that slot's instruction to wr_instr and its color bit to wr_color. Every other slot keeps its contents.
- R8: conflict_q is 1 exactly when two or more valid requests in the same cycle each have a nonzero masked slot on the same ALU. In that case vliw_q still carries the OR.
- R9: vliw_q and conflict_q appear one clock after the requests are presented. A read of a row in the same cycle as a write to it returns the contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Slot write enable |
| wr_row | input | ROW_W | Row to write |
| wr_slot | input | IDX_W | ALU slot to write |
| wr_instr | input | SLOT_W | Instruction bits for the slot |
| wr_color | input | 1 | Color bit for the slot |
| req_valid | input | NUM_REQ | Valid bit per request |
| req_row | input | NUM_REQ*ROW_W | Row per request, request k at [k*ROW_W +: ROW_W] |
| req_color | input | NUM_REQ | Color per request |
| vliw_q | output | NUM_ALU*SLOT_W | Registered merged instruction word |
| conflict_q | output | 1 | Registered flag: two requests hit the same ALU |

## Verification
Both vliw_q and conflict_q are due exactly one rising edge after the requests are driven. A write takes effect at that same edge, so it is first visible to requests driven in the following cycle. The bench drives every input on a falling edge and samples on the next falling edge, after one rising edge. It computes the expected word from its memory model as the model stood before that edge's write, and only then applies the write to the model. The same-cycle write and read case is checked this way as a directed case.

// File: rtl/vliw_imem.sv
module vliw_imem #(
  parameter int NUM_ALU = 8,
  parameter int SLOT_W  = 8,
  parameter int ROWS    = 32,
  parameter int NUM_REQ = 2,
  localparam int ROW_W  = $clog2(ROWS),
  localparam int IDX_W  = $clog2(NUM_ALU)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ROW_W-1:0]           wr_row,
  input  logic [IDX_W-1:0]           wr_slot,
  input  logic [SLOT_W-1:0]          wr_instr,
  input  logic                       wr_color,
  input  logic [NUM_REQ-1:0]         req_valid,
  input  logic [NUM_REQ*ROW_W-1:0]   req_row,
  input  logic [NUM_REQ-1:0]         req_color,
  output logic [NUM_ALU*SLOT_W-1:0]  vliw_q,
  output logic                       conflict_q
);

  logic [SLOT_W-1:0]  instr_mem [ROWS][NUM_ALU];
  logic [NUM_ALU-1:0] color_mem [ROWS];
  logic [SLOT_W-1:0]  masked    [NUM_REQ][NUM_ALU];
  logic [SLOT_W-1:0]  merged    [NUM_ALU];
  logic [NUM_ALU-1:0] seen, clash;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int r = 0; r < ROWS; r++) begin
        color_mem[r] <= '0;
        for (int a = 0; a < NUM_ALU; a++) instr_mem[r][a] <= '0;
      end
    end else if (wr_en && wr_row != '0) begin
      instr_mem[wr_row][wr_slot] <= wr_instr;
      color_mem[wr_row][wr_slot] <= wr_color;
    end
  end

  for (genvar k = 0; k < NUM_REQ; k++) begin : g_req
    wire [ROW_W-1:0] row = req_row[k*ROW_W +: ROW_W];
    for (genvar a = 0; a < NUM_ALU; a++) begin : g_alu
      assign masked[k][a] = (req_valid[k] && color_mem[row][a] == req_color[k])
                            ? instr_mem[row][a] : '0;
    end
  end

  always_comb begin
    for (int a = 0; a < NUM_ALU; a++) begin
      merged[a] = '0;
      seen[a]   = 1'b0;
      clash[a]  = 1'b0;
      for (int k = 0; k < NUM_REQ; k++) begin
        if (masked[k][a] != '0) begin
          if (seen[a]) clash[a] = 1'b1;
          seen[a] = 1'b1;
        end
        merged[a] = merged[a] | masked[k][a];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vliw_q     <= '0;
      conflict_q <= 1'b0;
    end else begin
      for (int a = 0; a < NUM_ALU; a++) vliw_q[a*SLOT_W +: SLOT_W] <= merged[a];
      conflict_q <= |clash;
    end
  end

endmodule

// File: rtl/vliw_imem_chk.sv
module vliw_imem_chk #(
  parameter int NUM_ALU = 8,
  parameter int SLOT_W  = 8,
  parameter int ROWS    = 32,
  parameter int NUM_REQ = 2,
  localparam int ROW_W  = $clog2(ROWS)
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NUM_REQ-1:0]        req_valid,
  input logic [NUM_REQ*ROW_W-1:0]  req_row,
  input logic [NUM_ALU*SLOT_W-1:0] vliw_q,
  input logic                      conflict_q
);

  logic only_noop;
  always_comb begin
    only_noop = 1'b1;
    for (int k = 0; k < NUM_REQ; k++)
      if (req_valid[k] && req_row[k*ROW_W +: ROW_W] != '0) only_noop = 1'b0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (vliw_q == '0 && !conflict_q));

  assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid == '0) |=> (vliw_q == '0 && !conflict_q));

  assert_noop_row_R6: assert property (@(posedge clk) disable iff (rst)
    only_noop |=> (vliw_q == '0));

  assert_conflict_needs_two_R8: assert property (@(posedge clk) disable iff (rst)
    ($countones(req_valid) < 2) |=> !conflict_q);

endmodule

bind vliw_imem vliw_imem_chk #(
  .NUM_ALU(NUM_ALU), .SLOT_W(SLOT_W), .ROWS(ROWS), .NUM_REQ(NUM_REQ)
) i_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_row(req_row),
  .vliw_q(vliw_q), .conflict_q(conflict_q)
);

// File: tb/test_vliw_imem.sv
module test_vliw_imem;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8, SW = 8, NR = 32, NQ = 2, RW = 5, IW = 3;

  logic clk = 0, rst = 1;
  logic wr_en = 0, wr_color = 0;
  logic [RW-1:0] wr_row = '0;
  logic [IW-1:0] wr_slot = '0;
  logic [SW-1:0] wr_instr = '0;
  logic [NQ-1:0] req_valid = '0, req_color = '0;
  logic [NQ*RW-1:0] req_row = '0;
  logic [NA*SW-1:0] vliw_q;
  logic conflict_q;

  int checks = 0, fails = 0;
  logic [SW-1:0] m_instr [NR][NA];
  logic [NA-1:0] m_color [NR];

  always #(CLK_PERIOD/2) clk = ~clk;

  vliw_imem #(.NUM_ALU(NA), .SLOT_W(SW), .ROWS(NR), .NUM_REQ(NQ)) i_vliw_imem (.*);

  task automatic check(input string req, input logic [NA*SW-1:0] got_w, exp_w,
                       input logic got_c, exp_c);
    checks++;
    if (got_w !== exp_w || got_c !== exp_c) begin
      fails++;
      $display("FAIL %s: vliw=%h conflict=%b expected vliw=%h conflict=%b",
               req, got_w, got_c, exp_w, exp_c);
    end
  endtask

  task automatic model_out(input logic [NQ-1:0] v, input logic [NQ*RW-1:0] rows,
                           input logic [NQ-1:0] cols,
                           output logic [NA*SW-1:0] w, output logic cf);
    w = '0; cf = 0;
    for (int a = 0; a < NA; a++) begin
      int hits = 0;
      for (int k = 0; k < NQ; k++) begin
        int r = int'(rows[k*RW +: RW]);
        if (v[k] && m_color[r][a] == cols[k] && m_instr[r][a] != 0) begin
          w[a*SW +: SW] |= m_instr[r][a];
          hits++;
        end
      end
      if (hits > 1) cf = 1;
    end
  endtask

  task automatic step(input string req, input logic we, input int wrow, wslot,
                      input logic [SW-1:0] winstr, input logic wcol,
                      input logic [NQ-1:0] v, input int r0, c0, r1, c1);
    logic [NA*SW-1:0] ew; logic ec;
    wr_en = we; wr_row = RW'(wrow); wr_slot = IW'(wslot);
    wr_instr = winstr; wr_color = wcol;
    req_valid = v; req_row = {RW'(r1), RW'(r0)}; req_color = {c1[0], c0[0]};
    model_out(req_valid, req_row, req_color, ew, ec);
    @(posedge clk); @(negedge clk);
    check(req, vliw_q, ew, conflict_q, ec);
    if (we && wrow != 0) begin
      m_instr[wrow][wslot] = winstr;
      m_color[wrow][wslot] = wcol;
    end
    wr_en = 0;
  endtask

  task automatic wr(input int row, slot, input logic [SW-1:0] val, input logic col);
    step("R7 write", 1, row, slot, val, col, 2'b00, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NA*SW-1:0] ew;
    void'($urandom(32'd4242));
    for (int r = 0; r < NR; r++) begin
      m_color[r] = '0;
      for (int a = 0; a < NA; a++) m_instr[r][a] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset outputs", vliw_q, '0, conflict_q, 0);
    step("R1 empty memory", 0, 0, 0, 0, 0, 2'b11, 7, 0, 31, 1);
    step("R1 empty memory", 0, 0, 0, 0, 0, 2'b11, 12, 1, 3, 0);

    wr(3, 0, 8'hA5, 0);
    wr(3, 1, 8'h3C, 1);
    wr(3, 7, 8'h81, 0);
    step("R2 single color0", 0, 0, 0, 0, 0, 2'b01, 3, 0, 0, 0);
    ew = '0; ew[7:0] = 8'hA5; ew[63:56] = 8'h81;
    check("R2 explicit value", vliw_q, ew, conflict_q, 0);
    step("R5 color1 only", 0, 0, 0, 0, 0, 2'b10, 0, 0, 3, 1);
    step("R5 both colors merged", 0, 0, 0, 0, 0, 2'b11, 3, 0, 3, 1);
    ew[15:8] = 8'h3C;
    check("R4 explicit union", vliw_q, ew, conflict_q, 0);
    step("R3 invalid request", 0, 0, 0, 0, 0, 2'b00, 3, 0, 3, 1);
    check("R3 invalid explicit zero", vliw_q, '0, conflict_q, 0);

    wr(0, 2, 8'hFF, 0);
    wr(0, 5, 8'h77, 1);
    step("R6 noop row color0", 0, 0, 0, 0, 0, 2'b11, 0, 0, 0, 1);
    check("R6 noop explicit zero", vliw_q, '0, conflict_q, 0);

    wr(5, 2, 8'h11, 0);
    wr(6, 2, 8'h22, 1);
    step("R8 clash", 0, 0, 0, 0, 0, 2'b11, 5, 0, 6, 1);
    ew = '0; ew[23:16] = 8'h33;
    check("R8 explicit clash", vliw_q, ew, conflict_q, 1);
    step("R8 masked no clash", 0, 0, 0, 0, 0, 2'b11, 5, 0, 6, 0);

    step("R9 read before write", 1, 5, 2, 8'hEE, 0, 2'b01, 5, 0, 0, 0);
    ew = '0; ew[23:16] = 8'h11;
    check("R9 old value", vliw_q, ew, conflict_q, 0);
    step("R9 new value next", 0, 0, 0, 0, 0, 2'b01, 5, 0, 0, 0);

    for (int i = 0; i < 400; i++) begin
      int rr = (i % 4 == 0) ? 0 : int'($urandom_range(NR-1));
      step("R4 random", logic'($urandom_range(1)), rr, int'($urandom_range(NA-1)),
           SW'($urandom_range(3) == 0 ? 0 : $urandom), logic'($urandom_range(1)),
           NQ'($urandom), int'($urandom_range(7)), int'($urandom_range(1)),
           int'($urandom_range(7)), int'($urandom_range(1)));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule